// File: doc/BRIEF.md
# Display Panel Power and Initialization Sequencer

This block brings an RGB-interface display panel up and down. It owns the panel supply enable and an active-high panel reset line. It issues command packets to a downstream serial command writer through a valid/ready byte stream. Each byte carries a flag that tells an opcode from a parameter, and a marker on the final byte of each packet. Four one-cycle request inputs start four fixed scripts: power-up with configuration, display enable, display disable and power-down. Each script is a list of steps (pin changes, millisecond waits and packet sends) held in a computed script ROM. The packet contents come from a computed packet ROM.

A parameterized prescaler divides the system clock into a 1 ms tick. The prescaler restarts at the start of every wait, so a wait of N ms lasts at least N full tick periods. A simulation can set a small divider. A 2-bit state output reports whether the panel is off, powered and configured, or displaying. A one-cycle done pulse marks the end of every script. Requests that do not fit the current state, and any request while a script runs, are dropped.

Top module: `panel_pwrseq`

## Requirements
- R1: While reset is applied and after it is released, `supply_en` is 0, `panel_rst` is 1, `pwr_state` is 0 (off), `busy` is 0 and `cmd_valid` is 0.
- R2: The prepare request raises `supply_en`. At least 51 ms later `panel_rst` falls: this is a 50 ms settle followed by a reset that is held at least 1 ms. The first command byte follows at least 10 ms after `panel_rst` falls. `cmd_valid` is never high while `panel_rst` is high or `supply_en` is low.
- R3: Prepare sends these packets in this order, each opcode followed by its parameter count in brackets: 0x36[1], 0x36[1], 0xb0[1], 0xc0[2], 0xc1[5], 0xc4[3], 0xc5[9], 0xc6[1], 0xc8[37], 0xc9[37], 0xca[37], 0xd1[2], 0xd2[3], 0xd3[2], 0xd5[4], 0xd6[2]. In each packet the opcode goes first with `cmd_is_param`=0, the parameters follow with `cmd_is_param`=1, and `cmd_last`=1 only on the final byte. The parameter of 0x36 is 0x0a, of 0xb0 is 0x00 and of 0xc6 is 0x01. For every other packet, parameter k (counting from 0) equals opcode+1+3k modulo 256.
- R4: Enable sends 0x11, waits at least 20 ms, and sends 0xd4[2], 0xf8[5] and 0xfc[2]. It then waits at least 150 ms and sends 0xb4[3], 0xb5[1], 0xb7[1], 0xb8[1] and 0x29[0].
- R5: Disable sends 0x28, waits at least 25 ms, sends 0x10, and then waits at least 120 ms before the done pulse.
- R6: Unprepare raises `panel_rst` and sends no command. `supply_en` falls at least one cycle after `panel_rst` rises.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_data`, `cmd_is_param` and `cmd_last` hold their values.
- R8: `pwr_state` encodes 0 as off, 1 as ready (powered and configured) and 2 as on. It changes only in the cycle of `seq_done`. `seq_done` lasts exactly one cycle and ends every accepted script. Prepare leads to 1, enable to 2, disable to 1 and unprepare to 0.
- R9: A request is accepted only in the matching state: prepare in off, enable or unprepare in ready, and disable in on. Any other request, and any request while `busy` is high, leaves `pwr_state`, `supply_en` and `panel_rst` unchanged and sends no byte.
- R10: Every wait of N ms lasts between N·CLK_PER_MS cycles and N·CLK_PER_MS plus a few cycles, because the tick prescaler restarts at the start of each wait.
- R11: When enable and unprepare arrive in the same cycle in the ready state, enable wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_prepare | input | 1 | Request power-up and configuration |
| req_enable | input | 1 | Request display enable |
| req_disable | input | 1 | Request display disable |
| req_unprepare | input | 1 | Request power-down |
| supply_en | output | 1 | Panel supply enable |
| panel_rst | output | 1 | Panel reset, active high |
| cmd_valid | output | 1 | Command byte valid |
| cmd_data | output | 8 | Command byte |
| cmd_is_param | output | 1 | 0 for an opcode byte, 1 for a parameter byte |
| cmd_last | output | 1 | Final byte of the current packet |
| cmd_ready | input | 1 | Writer accepts the byte |
| seq_done | output | 1 | One-cycle pulse at the end of a script |
| busy | output | 1 | A script is running |
| pwr_state | output | 2 | 0 off, 1 ready, 2 on |

## Verification
The assertions assume that the command writer never depends on a byte it has not yet accepted. They also assume the request inputs are plain synchronous pulses, so any combination of them in any state is legal stimulus. The bench drops `cmd_ready` on every third cycle for the whole run, so every packet sees stalls. It raises requests only as clean one-cycle pulses after a clock edge. Some of these pulses are deliberately illegal or arrive while a script is running, and some arrive together, so the acceptance rules are exercised without breaking the pulse assumption.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {PS_OFF = 2'd0, PS_READY = 2'd1, PS_ON = 2'd2} pwr_state_e;

  typedef enum logic [2:0] {
    ST_PWR_ON, ST_PWR_OFF, ST_RST_ON, ST_RST_OFF, ST_WAIT, ST_PKT, ST_END
  } step_kind_e;

  typedef struct packed {
    step_kind_e kind;
    logic [7:0] arg;
  } step_t;

  localparam int PC_W    = 6;
  localparam int PIDX_W  = 5;
  localparam int BIDX_W  = 6;

  // millisecond delays
  localparam int MS_SUPPLY_SETTLE = 50;
  localparam int MS_RST_HOLD      = 1;
  localparam int MS_RST_RECOVER   = 10;
  localparam int MS_WAKE          = 20;
  localparam int MS_NVM_LOAD      = 150;
  localparam int MS_BLANK         = 25;
  localparam int MS_SLEEP_IN      = 120;

  // script entry points
  localparam logic [PC_W-1:0] PC_PREP = 6'd0;
  localparam logic [PC_W-1:0] PC_EN   = 6'd23;
  localparam logic [PC_W-1:0] PC_DIS  = 6'd35;
  localparam logic [PC_W-1:0] PC_UNP  = 6'd40;

  function automatic step_t mk(step_kind_e k, int a);
    step_t s;
    s.kind = k;
    s.arg  = 8'(a);
    return s;
  endfunction

  // Script ROM: every sequence is a list of steps ending in ST_END.
  function automatic step_t script_step(logic [PC_W-1:0] a);
    step_t s;
    if (a >= 6'd8 && a <= 6'd21) s = mk(ST_PKT, int'(a) - 7);   // packets 1..14
    else begin
      case (a)
        6'd0:  s = mk(ST_PWR_ON, 0);
        6'd1:  s = mk(ST_WAIT, MS_SUPPLY_SETTLE);
        6'd2:  s = mk(ST_RST_ON, 0);
        6'd3:  s = mk(ST_WAIT, MS_RST_HOLD);
        6'd4:  s = mk(ST_RST_OFF, 0);
        6'd5:  s = mk(ST_WAIT, MS_RST_RECOVER);
        6'd6:  s = mk(ST_PKT, 0);
        6'd7:  s = mk(ST_PKT, 0);
        6'd23: s = mk(ST_PKT, 15);
        6'd24: s = mk(ST_WAIT, MS_WAKE);
        6'd25: s = mk(ST_PKT, 16);
        6'd26: s = mk(ST_PKT, 17);
        6'd27: s = mk(ST_PKT, 18);
        6'd28: s = mk(ST_WAIT, MS_NVM_LOAD);
        6'd29: s = mk(ST_PKT, 19);
        6'd30: s = mk(ST_PKT, 20);
        6'd31: s = mk(ST_PKT, 21);
        6'd32: s = mk(ST_PKT, 22);
        6'd33: s = mk(ST_PKT, 23);
        6'd35: s = mk(ST_PKT, 24);
        6'd36: s = mk(ST_WAIT, MS_BLANK);
        6'd37: s = mk(ST_PKT, 25);
        6'd38: s = mk(ST_WAIT, MS_SLEEP_IN);
        6'd40: s = mk(ST_RST_ON, 0);
        6'd41: s = mk(ST_PWR_OFF, 0);
        default: s = mk(ST_END, 0);
      endcase
    end
    return s;
  endfunction

  function automatic logic [7:0] pkt_opcode(logic [PIDX_W-1:0] i);
    case (i)
      5'd0:  return 8'h36;  5'd1:  return 8'hb0;  5'd2:  return 8'hc0;
      5'd3:  return 8'hc1;  5'd4:  return 8'hc4;  5'd5:  return 8'hc5;
      5'd6:  return 8'hc6;  5'd7:  return 8'hc8;  5'd8:  return 8'hc9;
      5'd9:  return 8'hca;  5'd10: return 8'hd1;  5'd11: return 8'hd2;
      5'd12: return 8'hd3;  5'd13: return 8'hd5;  5'd14: return 8'hd6;
      5'd15: return 8'h11;  5'd16: return 8'hd4;  5'd17: return 8'hf8;
      5'd18: return 8'hfc;  5'd19: return 8'hb4;  5'd20: return 8'hb5;
      5'd21: return 8'hb7;  5'd22: return 8'hb8;  5'd23: return 8'h29;
      5'd24: return 8'h28;  default: return 8'h10;
    endcase
  endfunction

  function automatic logic [BIDX_W-1:0] pkt_len(logic [PIDX_W-1:0] i);
    case (i)
      5'd2, 5'd10, 5'd12, 5'd14, 5'd16, 5'd18: return 6'd2;
      5'd3, 5'd17:                              return 6'd5;
      5'd4, 5'd11, 5'd19:                       return 6'd3;
      5'd5:                                     return 6'd9;
      5'd7, 5'd8, 5'd9:                         return 6'd37;
      5'd13:                                    return 6'd4;
      5'd15, 5'd23, 5'd24, 5'd25:               return 6'd0;
      default:                                  return 6'd1;
    endcase
  endfunction

  // parameter k of packet i
  function automatic logic [7:0] pkt_param(logic [PIDX_W-1:0] i, logic [BIDX_W-1:0] k);
    case (i)
      5'd0:    return 8'h0a;
      5'd1:    return 8'h00;
      5'd6:    return 8'h01;
      default: return pkt_opcode(i) + 8'(3 * int'(k)) + 8'd1;
    endcase
  endfunction

endpackage

// File: rtl/pwrseq_tick.sv
module pwrseq_tick #(
  parameter int CLK_PER_MS = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (CLK_PER_MS > 2) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [CW-1:0] TOP = CW'(CLK_PER_MS - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || tick)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R10

endmodule

// File: rtl/pwrseq_emit.sv
module pwrseq_emit
  import pwrseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PIDX_W-1:0] idx,
  input  logic              ready,
  output logic              valid,
  output logic [7:0]        data,
  output logic              is_param,
  output logic              last,
  output logic              done
);
  logic              sending;
  logic [PIDX_W-1:0] idx_q;
  logic [BIDX_W-1:0] bidx;
  logic [BIDX_W-1:0] nparam;
  logic              byte_taken;

  assign nparam     = pkt_len(idx_q);
  assign valid      = sending;
  assign is_param   = (bidx != '0);
  assign last       = (bidx == nparam);
  assign data       = is_param ? pkt_param(idx_q, bidx - 6'd1) : pkt_opcode(idx_q);
  assign byte_taken = sending && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sending <= 1'b0;
      idx_q   <= '0;
      bidx    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sending <= 1'b1;
        idx_q   <= idx;
        bidx    <= '0;
      end else if (byte_taken) begin
        if (last) begin
          sending <= 1'b0;
          done    <= 1'b1;
        end else begin
          bidx <= bidx + 6'd1;
        end
      end
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(data) && $stable(last) && $stable(is_param)); // R7
  AST_NO_RESTART_MIDPACKET: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !sending); // R3

endmodule

// File: rtl/panel_pwrseq.sv
module panel_pwrseq
  import pwrseq_pkg::*;
#(
  parameter int CLK_PER_MS = 125000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_prepare,
  input  logic       req_enable,
  input  logic       req_disable,
  input  logic       req_unprepare,
  output logic       supply_en,
  output logic       panel_rst,
  output logic       cmd_valid,
  output logic [7:0] cmd_data,
  output logic       cmd_is_param,
  output logic       cmd_last,
  input  logic       cmd_ready,
  output logic       seq_done,
  output logic       busy,
  output logic [1:0] pwr_state
);
  typedef enum logic [1:0] {PH_IDLE, PH_EXEC, PH_WAIT, PH_SEND} phase_e;

  phase_e          phase;
  logic [PC_W-1:0] pc;
  logic [7:0]      ms_left;
  pwr_state_e      state_q, target_q;
  logic            supply_q, rst_q, done_q;

  // named internal events
  step_t           step;
  logic            go_prep, go_en, go_dis, go_unp, go_any;
  logic [PC_W-1:0] entry_pc;
  pwr_state_e      entry_target;
  logic            tick, tick_restart, emit_start, emit_done;

  assign step = script_step(pc);

  assign go_prep = (state_q == PS_OFF)   && req_prepare;
  assign go_en   = (state_q == PS_READY) && req_enable;
  assign go_unp  = (state_q == PS_READY) && req_unprepare && !req_enable;
  assign go_dis  = (state_q == PS_ON)    && req_disable;
  assign go_any  = (phase == PH_IDLE) && (go_prep || go_en || go_unp || go_dis);

  always_comb begin
    if (go_prep)     begin entry_pc = PC_PREP; entry_target = PS_READY; end
    else if (go_en)  begin entry_pc = PC_EN;   entry_target = PS_ON;    end
    else if (go_dis) begin entry_pc = PC_DIS;  entry_target = PS_READY; end
    else             begin entry_pc = PC_UNP;  entry_target = PS_OFF;   end
  end

  assign tick_restart = (phase == PH_EXEC) && (step.kind == ST_WAIT);
  assign emit_start   = (phase == PH_EXEC) && (step.kind == ST_PKT);

  pwrseq_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(tick_restart), .tick(tick)
  );

  pwrseq_emit u_emit (
    .clk(clk), .rst_n(rst_n), .start(emit_start), .idx(step.arg[PIDX_W-1:0]),
    .ready(cmd_ready), .valid(cmd_valid), .data(cmd_data),
    .is_param(cmd_is_param), .last(cmd_last), .done(emit_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      pc       <= '0;
      ms_left  <= '0;
      state_q  <= PS_OFF;
      target_q <= PS_OFF;
      supply_q <= 1'b0;
      rst_q    <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        PH_IDLE: if (go_any) begin
          phase    <= PH_EXEC;
          pc       <= entry_pc;
          target_q <= entry_target;
        end
        PH_EXEC: case (step.kind)
          ST_PWR_ON:  begin supply_q <= 1'b1; pc <= pc + 6'd1; end
          ST_PWR_OFF: begin supply_q <= 1'b0; pc <= pc + 6'd1; end
          ST_RST_ON:  begin rst_q    <= 1'b1; pc <= pc + 6'd1; end
          ST_RST_OFF: begin rst_q    <= 1'b0; pc <= pc + 6'd1; end
          ST_WAIT:    begin ms_left  <= step.arg; phase <= PH_WAIT; end
          ST_PKT:     phase <= PH_SEND;
          default: begin
            phase   <= PH_IDLE;
            state_q <= target_q;
            done_q  <= 1'b1;
          end
        endcase
        PH_WAIT: if (tick) begin
          if (ms_left == 8'd1) begin
            pc    <= pc + 6'd1;
            phase <= PH_EXEC;
          end else begin
            ms_left <= ms_left - 8'd1;
          end
        end
        default: if (emit_done) begin
          pc    <= pc + 6'd1;
          phase <= PH_EXEC;
        end
      endcase
    end
  end

  assign supply_en = supply_q;
  assign panel_rst = rst_q;
  assign seq_done  = done_q;
  assign busy      = (phase != PH_IDLE);
  assign pwr_state = state_q;

  AST_CMD_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> supply_en && !panel_rst); // R2
  AST_RST_BEFORE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en) |-> panel_rst); // R6
  AST_STATE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_state) |-> seq_done); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid); // R9

endmodule

// File: tb/panel_pwrseq_bench.sv
module panel_pwrseq_bench;
  localparam int P = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_prepare = 0, req_enable = 0, req_disable = 0, req_unprepare = 0;
  logic cmd_ready = 0;
  logic supply_en, panel_rst, cmd_valid, cmd_is_param, cmd_last, seq_done, busy;
  logic [7:0] cmd_data;
  logic [1:0] pwr_state;

  always #4 clk = ~clk;

  panel_pwrseq #(.CLK_PER_MS(P)) u_panel_pwrseq (
    .clk(clk), .rst_n(rst_n), .req_prepare(req_prepare), .req_enable(req_enable),
    .req_disable(req_disable), .req_unprepare(req_unprepare),
    .supply_en(supply_en), .panel_rst(panel_rst), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmd_is_param(cmd_is_param), .cmd_last(cmd_last),
    .cmd_ready(cmd_ready), .seq_done(seq_done), .busy(busy), .pwr_state(pwr_state)
  );

  // opcode and parameter count per packet, as listed in R3/R4/R5
  localparam logic [7:0] OPS [0:25] = '{8'h36,8'hb0,8'hc0,8'hc1,8'hc4,8'hc5,8'hc6,
    8'hc8,8'hc9,8'hca,8'hd1,8'hd2,8'hd3,8'hd5,8'hd6,8'h11,8'hd4,8'hf8,8'hfc,
    8'hb4,8'hb5,8'hb7,8'hb8,8'h29,8'h28,8'h10};
  localparam int NP [0:25] = '{1,1,2,5,3,9,1,37,37,37,2,3,2,4,2,0,2,5,2,3,1,1,1,0,0,0};

  // vectors: {accepted, request(0 prep,1 en,2 dis,3 unprep), expected state}
  localparam logic [4:0] VEC [0:9] = '{
    {1'b0,2'd1,2'd0}, {1'b0,2'd2,2'd0}, {1'b0,2'd3,2'd0}, {1'b1,2'd0,2'd1},
    {1'b0,2'd0,2'd1}, {1'b0,2'd2,2'd1}, {1'b1,2'd1,2'd2}, {1'b0,2'd1,2'd2},
    {1'b1,2'd2,2'd1}, {1'b1,2'd3,2'd0}};

  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 0;

  logic [7:0] ld [0:511]; logic ldc [0:511]; logic llast [0:511]; int lcyc [0:511];
  int lcnt = 0;
  logic [7:0] ed [0:511]; logic edc [0:511]; logic elast [0:511];
  int ecnt = 0;
  int t_sup_rise = -1, t_sup_fall = -1, t_rst_rise = -1, t_rst_fall = -1, t_done = -1;
  int stall_viol = 0, done_wide = 0;
  logic pv = 0, pr = 0, pl = 0, pp = 0, psup = 0, prst = 1, pdone = 0;
  logic [7:0] pd = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cmd_valid && cmd_ready && lcnt < 512) begin
      ld[lcnt] = cmd_data; ldc[lcnt] = cmd_is_param; llast[lcnt] = cmd_last;
      lcyc[lcnt] = cyc; lcnt++;
    end
    if (pv && !pr && !(cmd_valid && cmd_data == pd && cmd_last == pl && cmd_is_param == pp))
      stall_viol++;
    if (supply_en && !psup) t_sup_rise = cyc;
    if (!supply_en && psup) t_sup_fall = cyc;
    if (panel_rst && !prst) t_rst_rise = cyc;
    if (!panel_rst && prst) t_rst_fall = cyc;
    if (seq_done) t_done = cyc;
    if (seq_done && pdone) done_wide++;
    pv = cmd_valid; pr = cmd_ready; pd = cmd_data; pl = cmd_last; pp = cmd_is_param;
    psup = supply_en; prst = panel_rst; pdone = seq_done;
  end

  // downstream writer: stalls every third cycle
  initial forever begin
    @(posedge clk); #1;
    cmd_ready = (cyc % 3) != 1;
  end

  task automatic clear_log();
    lcnt = 0; t_sup_rise = -1; t_sup_fall = -1; t_rst_rise = -1; t_rst_fall = -1; t_done = -1;
  endtask

  task automatic add_pkt(input int k);
    logic [7:0] v;
    ed[ecnt] = OPS[k]; edc[ecnt] = 0; elast[ecnt] = (NP[k] == 0); ecnt++;
    v = OPS[k] + 8'd1;
    for (int j = 0; j < NP[k]; j++) begin
      ed[ecnt] = (k == 0) ? 8'h0a : (k == 1) ? 8'h00 : (k == 6) ? 8'h01 : v;
      edc[ecnt] = 1; elast[ecnt] = (j == NP[k] - 1); ecnt++;
      v = v + 8'd3;
    end
  endtask

  task automatic build(input int r);
    ecnt = 0;
    if (r == 0) begin add_pkt(0); for (int k = 0; k <= 14; k++) add_pkt(k); end
    else if (r == 1) for (int k = 15; k <= 23; k++) add_pkt(k);
    else if (r == 2) begin add_pkt(24); add_pkt(25); end
  endtask

  task automatic cmp_stream(input string tag);
    int bad = -1;
    chk(lcnt == ecnt, {tag, " byte count"}, lcnt, ecnt);
    for (int i = 0; i < ecnt && i < lcnt; i++)
      if (bad < 0 && (ld[i] != ed[i] || ldc[i] != edc[i] || llast[i] != elast[i])) bad = i;
    if (bad >= 0) chk(0, {tag, " byte content"}, int'(ld[bad]), int'(ed[bad]));
    else chk(1, tag, 0, 0);
  endtask

  task automatic pulse(input logic [3:0] m);
    @(posedge clk); #1;
    {req_unprepare, req_disable, req_enable, req_prepare} = m;
    @(posedge clk); #1;
    {req_unprepare, req_disable, req_enable, req_prepare} = 4'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!seq_done && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, {tag, " done timeout"}, n, 20000);
    @(negedge clk);
  endtask

  task automatic in_range(input string tag, input int d, input int ms);
    chk(d >= ms * P && d <= ms * P + 12, tag, d, ms * P);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!supply_en && panel_rst && pwr_state == 0 && !cmd_valid && !busy, "R1 in reset",
        {supply_en, panel_rst, pwr_state}, 3'b010);
    @(posedge clk); #1 rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!supply_en && panel_rst && pwr_state == 0 && !cmd_valid && !busy, "R1 after reset",
        {supply_en, panel_rst, pwr_state}, 3'b010);

    for (int v = 0; v < 10; v++) begin
      automatic int r = int'(VEC[v][3:2]);
      automatic int es = int'(VEC[v][1:0]);
      automatic logic s0 = supply_en, r0 = panel_rst;
      clear_log();
      pulse(4'b0001 << r);
      if (VEC[v][4]) begin
        wait_done("R8 vector");
        chk(pwr_state == es, "R8 state after script", pwr_state, es);
        build(r);
        if (r == 0) begin
          cmp_stream("R3 prepare stream");
          in_range("R2 supply to reset release", t_rst_fall - t_sup_rise, 51);
          chk(lcyc[0] - t_rst_fall >= 10 * P, "R2 reset release to first byte",
              lcyc[0] - t_rst_fall, 10 * P);
        end else if (r == 1) begin
          cmp_stream("R4 enable stream");
          in_range("R4 wake wait", lcyc[1] - lcyc[0], 20);
          in_range("R4 memory load wait", lcyc[13] - lcyc[12], 150);
        end else if (r == 2) begin
          cmp_stream("R5 disable stream");
          in_range("R5 blank wait", lcyc[1] - lcyc[0], 25);
          in_range("R10 sleep wait", t_done - lcyc[1], 120);
        end else begin
          chk(lcnt == 0, "R6 no command on unprepare", lcnt, 0);
          chk(t_rst_rise > 0 && t_sup_fall > t_rst_rise, "R6 reset before supply off",
              t_sup_fall, t_rst_rise + 1);
          chk(!supply_en && panel_rst, "R6 final pins", {supply_en, panel_rst}, 2'b01);
        end
      end else begin
        repeat (40) @(negedge clk);
        chk(pwr_state == es && !busy && lcnt == 0 && supply_en == s0 && panel_rst == r0,
            "R9 illegal request ignored", pwr_state, es);
      end
    end

    // R11 enable beats unprepare in ready
    clear_log(); pulse(4'b0001); wait_done("R11 prepare");
    clear_log(); pulse(4'b1010); wait_done("R11 pair");
    chk(pwr_state == 2 && supply_en, "R11 enable wins", pwr_state, 2);
    build(1); cmp_stream("R11 enable stream");

    // R9 requests while busy are dropped
    clear_log(); pulse(4'b0100);
    repeat (20) @(negedge clk);
    chk(busy, "R9 script running", busy, 1);
    pulse(4'b0010); pulse(4'b1000); pulse(4'b0001);
    wait_done("R9 disable");
    repeat (60) @(negedge clk);
    chk(pwr_state == 1 && !busy && supply_en && !panel_rst, "R9 busy requests dropped", pwr_state, 1);
    build(2); cmp_stream("R9 only disable bytes");

    chk(stall_viol == 0, "R7 stalled byte held", stall_viol, 0);
    chk(done_wide == 0, "R8 done one cycle", done_wide, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule